// File: doc/BRIEF.md
# Key-protected independent watchdog timer

This block is a watchdog for a system-on-chip. Software talks to it through a small 32-bit register bus. A write of a magic value to a key register starts the watchdog, refreshes it or opens and closes write access to its configuration. A 12-bit down-counter counts low-speed clock events through a selectable power-of-two prescaler. When the counter passes zero it raises a one-cycle reset request and starts over from the reload value. An optional early-warning flag goes up when the count matches a programmable compare value, so that software can refresh in time.

The low-speed clock reaches the block as a single-cycle strobe, `slow_tick`, synchronous to the bus clock, one strobe per low-speed edge. A configuration write, made while access is open, lands in a shadow copy and raises a busy bit in the status register. It takes effect only after three slow strobes. Software polls the busy bits before it relies on a new setting. Once started, the watchdog can only be stopped by a system reset.

Top module: `wdg_top`

## Requirements
- R1: After reset, the prescaler reads 0, reload reads 0xFFF, early-warning control reads 0, status reads 0 (stopped, nothing pending), access is closed, and `rst_req` and `ew_irq` are low.
- R2: Key register (only bits 15:0 compared): 0x5555 opens access. 0xCCCC and 0xAAAA leave the access state unchanged. 0x0000 and every other value close access.
- R3: A write to prescaler, reload or early-warning control while access is closed is ignored, so the register keeps its value, and it leaves the matching busy bit clear.
- R4: An accepted configuration write sets its busy bit (status bit 0 prescaler, bit 1 reload, bit 3 early warning; bit 2 always reads 0). The bit stays set until the third `slow_tick` after the write. The new value takes effect on that strobe.
- R5: Writing 0xCCCC starts the watchdog and sets status bit 8. Neither a lock key nor a reset request clears the bit; only the system reset does.
- R6: Start loads the counter with the active reload value R. The counter then steps once every D slow strobes. The step after the count reaches 0 gives a `rst_req` pulse exactly one bus cycle long and reloads R. With `slow_tick` high every cycle, the pulse follows the start write by (R+1)*D cycles, and every (R+1)*D cycles after that.
- R7: Writing 0xAAAA reloads the counter with R and restarts the prescaler. Refreshing more often than every (R+1)*D strobes prevents any reset request.
- R8: The 4-bit prescaler code c selects D = 2^(c+2). Code 6 gives 256. Codes above 8 act as code 8 (D = 1024).
- R9: Early-warning control holds the compare value in bits 11:0 and the enable in bit 15. While running and enabled, a count equal to the compare value sets the flag driving `ew_irq` one cycle later. A write to this register with bit 14 set clears the flag, whether or not access is open. Bit 14 reads back 0.
- R10: The version register (offset 0x3F4) returns the revision parameter (default 0x31) in bits 7:0 and ignores writes.
- R11: Register offsets: key 0x00, prescaler 0x04, reload 0x08, status 0x0C, early-warning control 0x14, version 0x3F4. The key register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| slow_tick | input | 1 | One-cycle strobe per low-speed clock edge |
| rst_req | output | 1 | One-cycle reset request |
| ew_irq | output | 1 | Early-warning interrupt flag |

## Verification
The assertions assume that `slow_tick` is a clean synchronous strobe and that `rst` is held for at least one edge. The busy-bit property also assumes that a cleared busy bit can only come from a strobe or from reset. The stimulus changes every input on the falling clock edge. It holds `slow_tick` at a fixed level or pulses it for exactly one cycle. It resets the block between scenarios, because a started watchdog cannot otherwise be stopped. It waits for all busy bits to clear before starting the counter, so that every timing check runs against settled settings.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W        = 12;
    localparam int PRE_CODE_W   = 4;
    localparam int PRE_CODE_MAX = 8;
    localparam int PSC_W        = PRE_CODE_MAX + 3;
    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int EW_W         = CNT_W + 1;

    localparam logic [ADDR_W-1:0] OFS_KEY  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_PRE  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_RLD  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_EWC  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_VER  = 12'h3F4;

    localparam logic [15:0] KEY_OPEN    = 16'h5555;
    localparam logic [15:0] KEY_START   = 16'hCCCC;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

    localparam int EWC_EN_BIT  = 15;
    localparam int EWC_CLR_BIT = 14;
    localparam int STAT_RUN_BIT = 8;

    typedef struct packed {
        logic start;
        logic refresh;
        logic open;
        logic close;
    } key_act_t;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cmp;
    } ew_cfg_t;

    function automatic key_act_t decode_key(input logic [15:0] k);
        key_act_t a;
        a.start   = (k == KEY_START);
        a.refresh = (k == KEY_REFRESH);
        a.open    = (k == KEY_OPEN);
        a.close   = !(a.start || a.refresh || a.open);
        return a;
    endfunction

    function automatic logic [PSC_W-1:0] pre_limit(input logic [PRE_CODE_W-1:0] code);
        logic [PRE_CODE_W-1:0] c;
        c = (code > PRE_CODE_W'(PRE_CODE_MAX)) ? PRE_CODE_W'(PRE_CODE_MAX) : code;
        return (PSC_W'(4) << c) - PSC_W'(1);
    endfunction

endpackage

// File: rtl/wdg_keyctl.sv
module wdg_keyctl
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [15:0] key_val,
    output logic        open_q,
    output logic        start_p,
    output logic        refresh_p
);
    key_act_t act;

    always_comb begin
        act       = decode_key(key_val);
        start_p   = key_wr && act.start;
        refresh_p = key_wr && act.refresh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (key_wr) begin
            if (act.open)
                open_q <= 1'b1;
            else if (act.close)
                open_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_sync_slot.sv
module wdg_sync_slot #(
    parameter int           W          = 12,
    parameter logic [W-1:0] RST_VAL    = '0,
    parameter int           SYNC_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] active_q,
    output logic         pend_q
);
    localparam int TW = $clog2(SYNC_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(SYNC_TICKS - 1);

    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RST_VAL;
            active_q <= RST_VAL;
            pend_q   <= 1'b0;
            tcnt_q   <= '0;
        end else if (wr_en) begin
            shadow_q <= wr_data;
            pend_q   <= 1'b1;
            tcnt_q   <= '0;
        end else if (pend_q && tick) begin
            if (tcnt_q == LAST) begin
                active_q <= shadow_q;
                pend_q   <= 1'b0;
                tcnt_q   <= '0;
            end else begin
                tcnt_q <= tcnt_q + TW'(1);
            end
        end
    end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slow_tick,
    input  logic                  start,
    input  logic                  refresh,
    input  logic [PRE_CODE_W-1:0] pre_code,
    input  logic [CNT_W-1:0]      rld_val,
    input  ew_cfg_t               ew_cfg,
    input  logic                  ew_clr,
    output logic                  running_q,
    output logic                  rst_req_q,
    output logic                  ew_flag_q
);
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PSC_W-1:0] lim;
    logic             step;

    always_comb begin
        lim  = pre_limit(pre_code);
        step = running_q && slow_tick && (psc_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            rst_req_q <= 1'b0;
            psc_q     <= '0;
            cnt_q     <= '1;
        end else begin
            rst_req_q <= 1'b0;
            if (start)
                running_q <= 1'b1;
            if (start || refresh) begin
                cnt_q <= rld_val;
                psc_q <= '0;
            end else if (running_q && slow_tick) begin
                if (step) begin
                    psc_q <= '0;
                    if (cnt_q == '0) begin
                        cnt_q     <= rld_val;
                        rst_req_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end else begin
                    psc_q <= psc_q + PSC_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ew_flag_q <= 1'b0;
        else if (ew_clr)
            ew_flag_q <= 1'b0;
        else if (running_q && ew_cfg.en && (cnt_q == ew_cfg.cmp))
            ew_flag_q <= 1'b1;
    end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter logic [7:0] REVISION   = 8'h31,
    parameter int         SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              slow_tick,
    output logic              rst_req,
    output logic              ew_irq
);
    logic wr, wr_key, wr_pre_w, wr_rld_w, wr_ewc_w, ew_clr;
    logic open_w, start_p, refresh_p, run_w;
    logic [3:0] pend_w;
    logic [2:0] slot_pend;

    logic [PRE_CODE_W-1:0] pre_sh, pre_act;
    logic [CNT_W-1:0]      rld_sh, rld_act;
    ew_cfg_t               ew_sh, ew_act;
    logic                  unused_bits;

    always_comb begin
        wr       = bus_sel && bus_wr;
        wr_key   = wr && (bus_addr == OFS_KEY);
        wr_pre_w = wr && open_w && (bus_addr == OFS_PRE);
        wr_rld_w = wr && open_w && (bus_addr == OFS_RLD);
        wr_ewc_w = wr && open_w && (bus_addr == OFS_EWC);
        ew_clr   = wr && (bus_addr == OFS_EWC) && bus_wdata[EWC_CLR_BIT];
        pend_w   = {slot_pend[2], 1'b0, slot_pend[1], slot_pend[0]};
    end

    assign unused_bits = ^{bus_wdata[DATA_W-1:16], bus_wdata[13:12]};

    wdg_keyctl u_key (
        .clk       (clk),
        .rst       (rst),
        .key_wr    (wr_key),
        .key_val   (bus_wdata[15:0]),
        .open_q    (open_w),
        .start_p   (start_p),
        .refresh_p (refresh_p)
    );

    wdg_sync_slot #(.W(PRE_CODE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre (
        .clk (clk), .rst (rst), .wr_en (wr_pre_w),
        .wr_data (bus_wdata[PRE_CODE_W-1:0]), .tick (slow_tick),
        .shadow_q (pre_sh), .active_q (pre_act), .pend_q (slot_pend[0])
    );

    wdg_sync_slot #(.W(CNT_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld (
        .clk (clk), .rst (rst), .wr_en (wr_rld_w),
        .wr_data (bus_wdata[CNT_W-1:0]), .tick (slow_tick),
        .shadow_q (rld_sh), .active_q (rld_act), .pend_q (slot_pend[1])
    );

    wdg_sync_slot #(.W(EW_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_ewc (
        .clk (clk), .rst (rst), .wr_en (wr_ewc_w),
        .wr_data ({bus_wdata[EWC_EN_BIT], bus_wdata[CNT_W-1:0]}), .tick (slow_tick),
        .shadow_q (ew_sh), .active_q (ew_act), .pend_q (slot_pend[2])
    );

    wdg_core u_core (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .start     (start_p),
        .refresh   (refresh_p),
        .pre_code  (pre_act),
        .rld_val   (rld_act),
        .ew_cfg    (ew_act),
        .ew_clr    (ew_clr),
        .running_q (run_w),
        .rst_req_q (rst_req),
        .ew_flag_q (ew_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PRE:  bus_rdata[PRE_CODE_W-1:0] = pre_sh;
            OFS_RLD:  bus_rdata[CNT_W-1:0]      = rld_sh;
            OFS_STAT: begin
                bus_rdata[3:0]          = pend_w;
                bus_rdata[STAT_RUN_BIT] = run_w;
            end
            OFS_EWC: begin
                bus_rdata[EWC_EN_BIT] = ew_sh.en;
                bus_rdata[CNT_W-1:0]  = ew_sh.cmp;
            end
            OFS_VER:  bus_rdata[7:0] = REVISION;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk (
    input logic       clk,
    input logic       rst,
    input logic       slow_tick,
    input logic       running,
    input logic       rst_req,
    input logic       ew_irq,
    input logic       open_st,
    input logic       wr_rld,
    input logic [3:0] pend
);
    // R6: reset request lasts one bus cycle
    a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R6: a reset request only comes from a running watchdog
    a_r6_req_needs_run: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> running);

    // R5: once running, stays running until system reset
    a_r5_run_sticky: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    // R3: a closed-access reload write does not raise its busy bit
    a_r3_locked_no_pend: assert property (@(posedge clk) disable iff (rst)
        (wr_rld && !open_st && !pend[1]) |=> !pend[1]);

    // R4: busy bits only drop on a slow strobe
    a_r4_pend_clear_on_tick: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend) & ~pend)) |-> $past(slow_tick));

    // R4: status bit 2 has no register behind it
    a_r4_bit2_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[0]) |-> !pend[2]);

    // R9: early warning rises only while running
    a_r9_ew_when_running: assert property (@(posedge clk) disable iff (rst)
        $rose(ew_irq) |-> running);
endmodule

bind wdg_top wdg_top_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .slow_tick (slow_tick),
    .running   (run_w),
    .rst_req   (rst_req),
    .ew_irq    (ew_irq),
    .open_st   (open_w),
    .wr_rld    (bus_sel && bus_wr && (bus_addr == wdg_pkg::OFS_RLD)),
    .pend      (pend_w)
);

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b0;
    logic        rst_req;
    logic        ew_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [11:0] A_KEY = 12'h000, A_PRE = 12'h004, A_RLD = 12'h008,
                            A_STAT = 12'h00C, A_EWC = 12'h014, A_VER = 12'h3F4;

    wdg_top u0 (
        .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .slow_tick (slow_tick), .rst_req (rst_req), .ew_irq (ew_irq)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        slow_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic setup(input logic [3:0] code, input logic [11:0] rl, input logic [31:0] ewc);
        logic [31:0] s;
        slow_tick = 1'b1;
        wr(A_KEY, 32'h5555);
        wr(A_PRE, {28'b0, code});
        wr(A_RLD, {20'b0, rl});
        wr(A_EWC, ewc);
        wr(A_KEY, 32'h0000);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rd(A_STAT, s);
            if (s[3:0] == 4'h0) break;
        end
    endtask

    task automatic cycles_to_req(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_req && n < 20000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(A_STAT, d); check("R1 status", d, 32'h0);
        rd(A_PRE, d);  check("R1 prescaler", d, 32'h0);
        rd(A_RLD, d);  check("R1 reload", d, 32'hFFF);
        rd(A_EWC, d);  check("R1 ewc", d, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
        check("R1 ew_irq", {31'b0, ew_irq}, 32'h0);
        rd(A_VER, d);  check("R10 version", d[7:0], 32'h31);
        rd(A_KEY, d);  check("R11 key reads 0", d, 32'h0);
        rd(12'h100, d); check("R11 unmapped reads 0", d, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(A_RLD, 32'h123);
        rd(A_STAT, d); check("R3 no busy on locked write", d, 32'h0);
        rd(A_RLD, d);  check("R3 locked reload kept", d, 32'hFFF);
        wr(A_KEY, 32'h5555);
        wr(A_KEY, 32'h1234);
        wr(A_PRE, 32'h3);
        rd(A_PRE, d);  check("R2 invalid key relocks", d, 32'h0);
        wr(A_KEY, 32'hFFFF_5555);
        wr(A_KEY, 32'hAAAA);
        wr(A_PRE, 32'h2);
        rd(A_PRE, d);  check("R2 refresh key keeps access open", d, 32'h2);
        wr(A_KEY, 32'h0000);
        wr(A_RLD, 32'h5);
        rd(A_RLD, d);  check("R2 lock key closes access", d, 32'hFFF);
        wr(A_VER, 32'h0);
        rd(A_VER, d);  check("R10 version ignores writes", d, 32'h31);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        do_reset();
        wr(A_KEY, 32'h5555);
        wr(A_RLD, 32'h0AB);
        rd(A_STAT, d); check("R4 reload busy bit 1", d, 32'h2);
        wr(A_EWC, 32'h0000_8007);
        rd(A_STAT, d); check("R4 ew busy bit 3", d, 32'hA);
        pulse_tick();
        pulse_tick();
        rd(A_STAT, d); check("R4 busy after two ticks", d, 32'hA);
        pulse_tick();
        rd(A_STAT, d); check("R4 busy clear on third tick", d, 32'h0);
        rd(A_RLD, d);  check("R11 reload readback", d, 32'h0AB);
        wr(A_PRE, 32'h1);
        rd(A_STAT, d); check("R4 prescaler busy bit 0", d, 32'h1);
    endtask

    task automatic t_count();
        logic [31:0] d;
        int n;
        do_reset();
        setup(4'd0, 12'd5, 32'h0);
        wr(A_KEY, 32'hCCCC);
        rd(A_STAT, d); check("R5 running bit", d, 32'h100);
        cycles_to_req(n);
        check("R6 first request (R+1)*D", n, 24);
        @(negedge clk);
        check("R6 request one cycle", {31'b0, rst_req}, 32'h0);
        cycles_to_req(n);
        check("R6 periodic request", n, 23);
        check("R9 no irq when disabled", {31'b0, ew_irq}, 32'h0);
        wr(A_KEY, 32'h0000);
        rd(A_STAT, d); check("R5 lock does not stop", d[8], 32'h1);
    endtask

    task automatic t_refresh();
        int n;
        int seen;
        do_reset();
        setup(4'd0, 12'd5, 32'h0);
        wr(A_KEY, 32'hCCCC);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            repeat (10) begin
                @(negedge clk);
                if (rst_req) seen++;
            end
            wr(A_KEY, 32'hAAAA);
        end
        check("R7 refresh prevents request", seen, 0);
        cycles_to_req(n);
        check("R7 request after last refresh", n, 24);
    endtask

    task automatic t_prescale(input logic [3:0] code, input int exp);
        int n;
        do_reset();
        setup(code, 12'd3, 32'h0);
        wr(A_KEY, 32'hCCCC);
        cycles_to_req(n);
        check($sformatf("R8 divider for code %0d", code), n, exp);
    endtask

    task automatic t_early();
        logic [31:0] d;
        int n;
        do_reset();
        setup(4'd0, 12'd5, 32'h0000_8002);
        rd(A_EWC, d); check("R9 ewc readback layout", d, 32'h8002);
        wr(A_KEY, 32'hCCCC);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ew_irq && n < 200);
        check("R9 irq when count equals compare", n, 13);
        repeat (7) @(negedge clk);
        wr(A_EWC, 32'h0000_4000);
        check("R9 write-one clear while locked", {31'b0, ew_irq}, 32'h0);
        rd(A_EWC, d); check("R9 locked clear keeps settings", d, 32'h8002);
    endtask

    initial begin
        t_reset();
        t_lock();
        t_sync();
        t_count();
        t_refresh();
        t_prescale(4'd1, 32);
        t_prescale(4'd6, 1024);
        t_prescale(4'd15, 4096);
        t_early();
        finish_run();
    end
endmodule